// File: doc/BRIEF.md
# Radix-4 Booth Recoded Multiplier

This block multiplies operand A by operand B and returns the full-width product. Operand A is scanned in overlapping three-bit windows, one per pair of bits. Each window is turned into a signed digit from the set {-2, -1, 0, +1, +2}. Each digit selects one partial product of B: zero, B, twice B, or the negation of one of these.

A negative partial product is built by inverting every selected bit and adding a single carry of 1 at that row's lowest weight. The top bit of each row, which carries a negative weight, is collected in a separate negative heap. The product is the positive heap minus the negative heap, modulo 2^(A_W+B_W). The width and the signedness of each operand are parameters.

An optional output register sits behind a valid/ready handshake. A new operand pair is accepted when `in_valid` and `in_ready` are both high. With the register enabled, `in_ready` is high whenever the output slot is empty or is being drained in the same cycle. A result that is held while `out_ready` is low stays unchanged. With the register disabled, the block is purely combinational and the handshake passes straight through.

Top module: `booth4_mult`

## Requirements
- R1: `out_product` equals A times B modulo 2^(A_W+B_W). Each operand is read as two's complement when its signedness parameter is 1, and as unsigned when it is 0.
- R2: The digit at even bit position i is formed from the multiplier bits (i+1, i, i-1), with an implicit 0 below bit 0. The windows map as follows: 001 and 010 give +B, 011 gives +2B, 100 gives -2B, and 101 and 110 give -B.
- R3: The windows 000 and 111 produce an all-zero row and no carry. An operand A of 0 therefore yields a product of 0 for any B.
- R4: A negative, non-zero digit inverts its selected row and injects a +1 carry at weight i. For a signed A, an A of -1 yields the product -B.
- R5: For an unsigned A of even width, one extra digit (0, 0, A MSB) is added, so an all-ones A gives a non-negative product. For example, 15 x 15 = 225 at 4x4 bits.
- R6: When the top window extends past the MSB of A, the missing bit is the sign bit for a signed A and 0 for an unsigned A. For example, signed 5x4 bits: -16 x -8 = 128, and 15 x -8 = -120.
- R7: With OUT_REG=1, an operand pair accepted at a clock edge appears on `out_product`, with `out_valid` high, after that edge.
- R8: With OUT_REG=1, `in_ready` is 0 while `out_valid` is 1 and `out_ready` is 0. During such a stall, `out_product` and `out_valid` hold their values.
- R9: With OUT_REG=1, reset clears `out_valid` and leaves `in_ready` at 1.
- R10: With OUT_REG=0, `out_valid` equals `in_valid`, `in_ready` equals `out_ready`, and the product is available in the same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the output register |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Operand pair is present |
| in_ready | output | 1 | Block can take an operand pair |
| in_a | input | A_W | Multiplier operand A (recoded) |
| in_b | input | B_W | Multiplicand operand B |
| out_valid | output | 1 | Product is present |
| out_ready | input | 1 | Consumer takes the product |
| out_product | output | A_W+B_W | Product A x B |

## Verification
The hardest case to reach is the handling of the top digit. The extra digit for an unsigned A of even width, and the sign fill for an odd-width or signed A, only affect the result when the MSB of A is set in combination with particular values of B. The bench therefore sweeps a signed 6-bit by unsigned 5-bit configuration exhaustively, which covers every recoding window. It adds further instances for the other signedness combinations with both even and odd widths, and drives extreme operands such as the most negative value and all-ones. Stall behaviour is reached by dropping `out_ready` while a result is held and offering a new operand pair at the same time.

// File: rtl/booth4_pkg.sv
package booth4_pkg;

  typedef struct packed {
    logic zero;  // row forced to zero
    logic dbl;   // select shifted multiplicand
    logic neg;   // negate selected row
  } booth_sel_t;

  function automatic booth_sel_t decode_window(input logic [2:0] w);
    booth_sel_t s;
    s.zero = (w == 3'b000) || (w == 3'b111);
    s.dbl  = (w == 3'b011) || (w == 3'b100);
    s.neg  = w[2];
    return s;
  endfunction

endpackage

// File: rtl/booth4_recoder.sv
module booth4_recoder #(
  parameter int A_W      = 8,
  parameter bit A_SIGNED = 1'b0,
  parameter int N_DIG    = 5
) (
  input  logic [A_W-1:0]          a,
  output logic [N_DIG-1:0][2:0]   windows
);
  localparam int AX_W = 2 * N_DIG + 1;

  logic [AX_W-1:0] ax;
  logic            fill;

  assign fill = A_SIGNED ? a[A_W-1] : 1'b0;

  always_comb begin
    ax = '0;
    ax[A_W:1] = a;
    for (int j = A_W + 1; j < AX_W; j++) ax[j] = fill;
  end

  for (genvar d = 0; d < N_DIG; d++) begin : g_win
    assign windows[d] = ax[2*d+2 -: 3];
  end

  // R5 R6: top window high bit is the sign fill
  always_comb begin
    if (!A_SIGNED) begin
      top_fill_chk: assert (windows[N_DIG-1][2] == 1'b0);
    end else begin
      top_sign_chk: assert (windows[N_DIG-1][2] == a[A_W-1]);
    end
  end
endmodule

// File: rtl/booth4_ppgen.sv
module booth4_ppgen
  import booth4_pkg::*;
#(
  parameter int B_W      = 8,
  parameter bit B_SIGNED = 1'b0
) (
  input  logic [2:0]      window,
  input  logic [B_W-1:0]  b,
  output logic [B_W:0]    pos_row,
  output logic [B_W+1:0]  neg_row,
  output logic            cin
);
  booth_sel_t    sel;
  logic [B_W:0]  mag;
  logic [B_W:0]  row;
  logic          b_ext;

  assign sel   = decode_window(window);
  assign b_ext = B_SIGNED ? b[B_W-1] : 1'b0;
  assign mag   = sel.dbl ? {b, 1'b0} : {b_ext, b};
  assign row   = sel.zero ? '0 : (sel.neg ? ~mag : mag);
  assign cin   = sel.neg & ~sel.zero;

  if (B_SIGNED) begin : g_signed_b
    assign pos_row = {1'b0, row[B_W-1:0]};
    assign neg_row = {1'b0, row[B_W], {B_W{1'b0}}};
  end else begin : g_unsigned_b
    assign pos_row = row;
    assign neg_row = {cin, {(B_W+1){1'b0}}};
  end

  always_comb begin
    // R3
    if (window == 3'b000 || window == 3'b111) begin
      zero_row_chk: assert (pos_row == '0 && neg_row == '0 && !cin);
    end
    // R4
    if (window == 3'b101 || window == 3'b110 || window == 3'b100) begin
      neg_carry_chk: assert (cin);
    end
  end
endmodule

// File: rtl/booth4_heap_sum.sv
module booth4_heap_sum #(
  parameter int B_W   = 8,
  parameter int N_DIG = 5,
  parameter int P_W   = 16
) (
  input  logic [N_DIG-1:0][B_W:0]   pos_rows,
  input  logic [N_DIG-1:0][B_W+1:0] neg_rows,
  input  logic [N_DIG-1:0]          cins,
  output logic [P_W-1:0]            product
);
  logic [P_W-1:0] pos_heap;
  logic [P_W-1:0] neg_heap;

  always_comb begin
    pos_heap = '0;
    neg_heap = '0;
    for (int d = 0; d < N_DIG; d++) begin
      pos_heap = pos_heap + (P_W'(pos_rows[d]) << (2 * d));
      pos_heap = pos_heap + (P_W'(cins[d]) << (2 * d));
      neg_heap = neg_heap + (P_W'(neg_rows[d]) << (2 * d));
    end
  end

  assign product = pos_heap - neg_heap;
endmodule

// File: rtl/booth4_mult.sv
module booth4_mult #(
  parameter int A_W      = 8,
  parameter int B_W      = 8,
  parameter bit A_SIGNED = 1'b0,
  parameter bit B_SIGNED = 1'b0,
  parameter bit OUT_REG  = 1'b1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 in_valid,
  output logic                 in_ready,
  input  logic [A_W-1:0]       in_a,
  input  logic [B_W-1:0]       in_b,
  output logic                 out_valid,
  input  logic                 out_ready,
  output logic [A_W+B_W-1:0]   out_product
);
  localparam int P_W   = A_W + B_W;
  localparam int N_DIG = A_SIGNED ? (A_W + 1) / 2 : A_W / 2 + 1;

  logic [N_DIG-1:0][2:0]     windows;
  logic [N_DIG-1:0][B_W:0]   pos_rows;
  logic [N_DIG-1:0][B_W+1:0] neg_rows;
  logic [N_DIG-1:0]          cins;
  logic [P_W-1:0]            comb_prod;

  booth4_recoder #(.A_W(A_W), .A_SIGNED(A_SIGNED), .N_DIG(N_DIG)) u_rec (
    .a(in_a), .windows(windows)
  );

  for (genvar d = 0; d < N_DIG; d++) begin : g_pp
    booth4_ppgen #(.B_W(B_W), .B_SIGNED(B_SIGNED)) u_pp (
      .window(windows[d]), .b(in_b),
      .pos_row(pos_rows[d]), .neg_row(neg_rows[d]), .cin(cins[d])
    );
  end

  booth4_heap_sum #(.B_W(B_W), .N_DIG(N_DIG), .P_W(P_W)) u_sum (
    .pos_rows(pos_rows), .neg_rows(neg_rows), .cins(cins), .product(comb_prod)
  );

  // behavioural product used only by the assertions
  logic signed [P_W:0] ref_a, ref_b, ref_full;
  always_comb begin
    ref_a    = A_SIGNED ? {{(P_W+1-A_W){in_a[A_W-1]}}, in_a} : {{(P_W+1-A_W){1'b0}}, in_a};
    ref_b    = B_SIGNED ? {{(P_W+1-B_W){in_b[B_W-1]}}, in_b} : {{(P_W+1-B_W){1'b0}}, in_b};
    ref_full = ref_a * ref_b;
  end

  if (OUT_REG) begin : g_reg
    logic           vld_q;
    logic [P_W-1:0] prod_q;

    assign in_ready = !vld_q || out_ready;

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        vld_q  <= 1'b0;
        prod_q <= '0;
      end else if (in_ready) begin
        vld_q <= in_valid;
        if (in_valid) prod_q <= comb_prod;
      end
    end

    assign out_valid   = vld_q;
    assign out_product = prod_q;

    // R1
    product_ok_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && in_ready) |=> out_product == $past(ref_full[P_W-1:0]));
    // R7
    accept_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && in_ready) |=> out_valid);
    // R8
    stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && !out_ready) |=> (out_valid && $stable(out_product)));
  end else begin : g_comb
    assign in_ready    = out_ready;
    assign out_valid   = in_valid;
    assign out_product = comb_prod;

    // R1
    comb_product_chk: assert property (@(posedge clk) disable iff (!rst_n)
      out_product == ref_full[P_W-1:0]);
  end
endmodule

// File: tb/test_booth4_mult.sv
module test_booth4_mult;
  localparam int MA = 6, MB = 5, MP = 11;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #5 clk = ~clk;

  int n_checks = 0, n_errs = 0;

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    n_checks++;
    if (!ok) begin
      n_errs++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // main: signed A 6b, unsigned B 5b, registered
  logic m_iv, m_ir, m_ov, m_or;
  logic [MA-1:0] m_a;
  logic [MB-1:0] m_b;
  logic [MP-1:0] m_p;
  booth4_mult #(.A_W(MA), .B_W(MB), .A_SIGNED(1), .B_SIGNED(0), .OUT_REG(1)) i_booth4_mult (
    .clk(clk), .rst_n(rst_n), .in_valid(m_iv), .in_ready(m_ir), .in_a(m_a), .in_b(m_b),
    .out_valid(m_ov), .out_ready(m_or), .out_product(m_p));

  // unsigned x unsigned 4x4, combinational
  logic [3:0] u_a, u_b; logic [7:0] u_p; logic u_iv, u_ir, u_ov, u_or;
  booth4_mult #(.A_W(4), .B_W(4), .A_SIGNED(0), .B_SIGNED(0), .OUT_REG(0)) i_uu (
    .clk(clk), .rst_n(rst_n), .in_valid(u_iv), .in_ready(u_ir), .in_a(u_a), .in_b(u_b),
    .out_valid(u_ov), .out_ready(u_or), .out_product(u_p));

  // signed x signed 5x4, combinational
  logic [4:0] s_a; logic [3:0] s_b; logic [8:0] s_p; logic s_ir, s_ov;
  booth4_mult #(.A_W(5), .B_W(4), .A_SIGNED(1), .B_SIGNED(1), .OUT_REG(0)) i_ss (
    .clk(clk), .rst_n(rst_n), .in_valid(1'b1), .in_ready(s_ir), .in_a(s_a), .in_b(s_b),
    .out_valid(s_ov), .out_ready(1'b1), .out_product(s_p));

  // unsigned A x signed B 8x7, combinational
  logic [7:0] r_a; logic [6:0] r_b; logic [14:0] r_p; logic r_ir, r_ov;
  booth4_mult #(.A_W(8), .B_W(7), .A_SIGNED(0), .B_SIGNED(1), .OUT_REG(0)) i_us (
    .clk(clk), .rst_n(rst_n), .in_valid(1'b1), .in_ready(r_ir), .in_a(r_a), .in_b(r_b),
    .out_valid(r_ov), .out_ready(1'b1), .out_product(r_p));

  // corner vectors for the main instance: {a, b, expected}
  typedef struct packed { logic [MA-1:0] a; logic [MB-1:0] b; logic [MP-1:0] p; } vec_t;
  localparam vec_t VECS [6] = '{
    '{6'h20, 5'd31, 11'h420},   // -32 * 31
    '{6'h1F, 5'd31, 11'h3C1},   //  31 * 31
    '{6'h3F, 5'd1,  11'h7FF},   //  -1 * 1 (R4)
    '{6'h00, 5'd31, 11'h000},   //   0 * 31 (R3)
    '{6'h01, 5'd16, 11'h010},   //   1 * 16
    '{6'h3E, 5'd17, 11'h7DE}    //  -2 * 17 (R2)
  };

  function automatic logic [MP-1:0] main_exp(input logic [MA-1:0] a, input logic [MB-1:0] b);
    longint ea = longint'($signed(a));
    longint eb = longint'(b);
    longint pr = ea * eb;
    return pr[MP-1:0];
  endfunction

  task automatic push_check(input logic [MA-1:0] a, input logic [MB-1:0] b,
                            input logic [MP-1:0] exp, input string req);
    @(negedge clk);
    m_a = a; m_b = b; m_iv = 1'b1;
    @(negedge clk);
    m_iv = 1'b0;
    check(m_ov === 1'b1, {req, " valid"}, longint'(m_ov), 1);
    check(m_p === exp, req, longint'(m_p), longint'(exp));
  endtask

  initial begin
    #2_000_000;
    n_errs++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errs);
    $finish;
  end

  initial begin
    m_iv = 0; m_or = 1; m_a = '0; m_b = '0;
    u_iv = 0; u_or = 0; u_a = '0; u_b = '0;
    s_a = '0; s_b = '0; r_a = '0; r_b = '0;
    repeat (3) @(negedge clk);
    // R9 reset state
    check(m_ov === 1'b0, "R9 out_valid in reset", longint'(m_ov), 0);
    check(m_ir === 1'b1, "R9 in_ready in reset", longint'(m_ir), 1);
    rst_n = 1'b1;

    for (int i = 0; i < 6; i++) push_check(VECS[i].a, VECS[i].b, VECS[i].p, "R1 R2 table");

    // R3 zero multiplier, R4 negative digit
    push_check(6'h00, 5'd21, 11'h000, "R3 zero A");
    push_check(6'h3F, 5'd23, 11'h7E9, "R4 -1*B");

    // R1 R2 exhaustive
    for (int a = 0; a < 64; a++)
      for (int b = 0; b < 32; b++)
        push_check(MA'(a), MB'(b), main_exp(MA'(a), MB'(b)), "R1 exhaustive");

    // R7 latency: output not valid before edge, valid after
    @(negedge clk);
    check(m_ov === 1'b0, "R7 idle", longint'(m_ov), 0);
    push_check(6'd5, 5'd7, 11'd35, "R7 one-edge latency");

    // R8 stall
    @(negedge clk);
    m_or = 1'b0; m_a = 6'd3; m_b = 5'd9; m_iv = 1'b1;
    @(negedge clk);
    m_a = 6'd10; m_b = 5'd10;
    check(m_ir === 1'b0, "R8 in_ready stalled", longint'(m_ir), 0);
    @(negedge clk);
    check(m_ov === 1'b1, "R8 valid held", longint'(m_ov), 1);
    check(m_p === 11'd27, "R8 product held", longint'(m_p), 27);
    m_or = 1'b1;
    @(negedge clk);
    m_iv = 1'b0;
    check(m_p === 11'd100, "R8 next after release", longint'(m_p), 100);

    // R5 unsigned even width extra digit, plus exhaustive uu
    u_a = 4'd15; u_b = 4'd15; #1;
    check(u_p === 8'd225, "R5 15*15", longint'(u_p), 225);
    for (int a = 0; a < 16; a++)
      for (int b = 0; b < 16; b++) begin
        u_a = 4'(a); u_b = 4'(b); #1;
        check(u_p === 8'(a * b), "R5 uu sweep", longint'(u_p), longint'(a * b));
      end

    // R10 combinational pass-through
    u_iv = 1'b1; u_or = 1'b0; #1;
    check(u_ov === 1'b1, "R10 valid through", longint'(u_ov), 1);
    check(u_ir === 1'b0, "R10 ready through", longint'(u_ir), 0);
    u_iv = 1'b0; u_or = 1'b1; #1;
    check(u_ov === 1'b0 && u_ir === 1'b1, "R10 handshake", longint'({u_ov, u_ir}), 1);

    // R6 signed fill
    s_a = 5'h10; s_b = 4'h8; #1;
    check(s_p === 9'd128, "R6 -16*-8", longint'(s_p), 128);
    s_a = 5'd15; s_b = 4'h8; #1;
    check(s_p === 9'd392, "R6 15*-8", longint'(s_p), 392);
    for (int a = -16; a < 16; a++)
      for (int b = -8; b < 8; b++) begin
        s_a = 5'(a); s_b = 4'(b); #1;
        check(s_p === 9'(a * b), "R6 ss sweep", longint'(s_p), longint'(9'(a * b)));
      end

    // R1 random unsigned A x signed B
    for (int k = 0; k < 500; k++) begin
      longint pr;
      r_a = 8'($urandom); r_b = 7'($urandom); #1;
      pr = longint'(r_a) * longint'($signed(r_b));
      check(r_p === pr[14:0], "R1 us random", longint'(r_p), longint'(pr[14:0]));
    end

    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errs);
    $finish;
  end
endmodule